// File: doc/BRIEF.md
# Configurable Logic Cell

A single logic cell for a small programmable fabric. A two-input lookup table computes any Boolean function of the two data inputs, and the cell output shows either that raw table result or a copy of it captured in a flip-flop, so the same cell serves combinational or sequential logic.

The table contents and the output-path choice form a five-bit configuration word. The word is held in a shift chain that loads one bit per clock while the configuration enable is high. The chain's far end leaves the cell on a serial output, so several cells can be strung into one long chain and programmed from a single serial stream. While the enable is low, the configuration is frozen and the datapath runs.

The flip-flop is cleared by an asynchronous active-low reset, which the surrounding logic releases in step with the clock. Reset does not touch the configuration chain.

Top module: `logic_cell`

## Requirements
- R1: With the path select at 0, `data_out` equals table bit k whenever `data_in` equals k. The table is indexed as {data_in[1], data_in[0]}. The output follows the inputs combinationally, with no clock edge in between.
- R2: With the path select at 1 and `cfg_en` low, each rising edge captures the table result for the inputs present before that edge, and `data_out` shows it from that edge onward. A change of `data_in` between edges does not alter `data_out`.
- R3: On each rising edge with `cfg_en` high, `cfg_si` enters the chain and every stored bit moves one place toward `cfg_so`. A five-bit load is sent in this order: table bits 0, 1, 2, 3, then the path select.
- R4: `cfg_so` presents the bit that entered the chain five shifting edges earlier. After a load, further shifting therefore returns table bits 0 to 3 and then the path select, in that order.
- R5: While `cfg_en` is high the flip-flop keeps its value, even when the table contents change underneath it.
- R6: While `cfg_en` is low, `cfg_si` has no effect. `cfg_so` and the configured function stay unchanged.
- R7: Asserting `rst_n` low clears the flip-flop at once, so that `data_out` reads 0 in registered mode. The configuration chain keeps its contents through reset and can be loaded while reset is held.
- R8: Two cells, with the first cell's `cfg_so` feeding the second cell's `cfg_si`, are programmed by ten shifts. The first five bits sent end up in the second cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop, released synchronously |
| cfg_en | input | 1 | High: shift the configuration chain and hold the flip-flop. Low: run the datapath |
| cfg_si | input | 1 | Serial configuration input |
| cfg_so | output | 1 | Serial configuration output, the far end of the chain |
| data_in | input | LUT_INPUTS (2) | Lookup inputs, with bit 1 as the high index bit |
| data_out | output | 1 | Cell output: combinational or registered table result |

## Verification
Each result is due at a different point in time. The combinational output is due as soon as the inputs settle, so the bench drives `data_in` on the falling edge and samples 1 ns later. A registered result is due at the first rising edge after the inputs change. The bench samples it at the following falling edge, and it also samples just before that rising edge to confirm the old value is still held. A configuration bit shifts on the rising edge while `cfg_en` is high, so `cfg_so` and the freshly loaded function are checked on the falling edge after the final shifting edge. The asynchronous clear of the flip-flop is checked 1 ns after `rst_n` falls, without waiting for a clock edge.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;

  // Output path choice held in the last configuration bit.
  typedef enum logic {
    SEL_COMB = 1'b0,
    SEL_REG  = 1'b1
  } out_sel_e;

  function automatic int unsigned table_size(input int unsigned n_inputs);
    return 32'd1 << n_inputs;
  endfunction

endpackage

// File: rtl/lc_cfg_chain.sv
// Serial configuration store. Bits enter at the top and leave at bit 0.
module lc_cfg_chain #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] cfg_q
);

  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) begin
      chain_d = {ser_in, chain_q[WIDTH-1:1]};
    end
  end

  // Configuration is deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    chain_q <= chain_d;
  end

  assign ser_out = chain_q[0];
  assign cfg_q   = chain_q;

endmodule

// File: rtl/lc_lut.sv
// Lookup table read port: selects one stored bit by the input vector.
module lc_lut #(
  parameter int unsigned N_IN = 2
) (
  input  logic [logic_cell_pkg::table_size(N_IN)-1:0] tbl,
  input  logic [N_IN-1:0]                             idx,
  output logic                                        y
);

  always_comb begin
    y = tbl[idx];
  end

endmodule

// File: rtl/lc_out_stage.sv
// Capture flip-flop plus output path multiplexer.
module lc_out_stage (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic                     d,
  input  logic_cell_pkg::out_sel_e sel,
  output logic                     ff_q,
  output logic                     y
);

  import logic_cell_pkg::*;

  logic ff_d;

  always_comb begin
    ff_d = ff_q;
    if (!hold) begin
      ff_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_REG: y = ff_q;
      default: y = d;
    endcase
  end

endmodule

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int unsigned LUT_INPUTS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_si,
  output logic                  cfg_so,
  input  logic [LUT_INPUTS-1:0] data_in,
  output logic                  data_out
);

  import logic_cell_pkg::*;

  localparam int unsigned TBL_BITS = table_size(LUT_INPUTS);
  localparam int unsigned CFG_BITS = TBL_BITS + 1;

  logic [CFG_BITS-1:0] cfg_q;
  logic [TBL_BITS-1:0] cfg_tbl;
  out_sel_e            cfg_sel;
  logic                lut_y;
  logic                ff_q;

  lc_cfg_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk      (clk),
    .shift_en (cfg_en),
    .ser_in   (cfg_si),
    .ser_out  (cfg_so),
    .cfg_q    (cfg_q)
  );

  // Table bits are loaded first and so sit at the low end; select is last.
  assign cfg_tbl = cfg_q[TBL_BITS-1:0];
  assign cfg_sel = out_sel_e'(cfg_q[CFG_BITS-1]);

  lc_lut #(.N_IN(LUT_INPUTS)) u_lut (
    .tbl (cfg_tbl),
    .idx (data_in),
    .y   (lut_y)
  );

  lc_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (cfg_en),
    .d     (lut_y),
    .sel   (cfg_sel),
    .ff_q  (ff_q),
    .y     (data_out)
  );

endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk #(
  parameter int unsigned LUT_INPUTS = 2
) (
  input logic                                                   clk,
  input logic                                                   rst_n,
  input logic                                                   cfg_en,
  input logic                                                   cfg_so,
  input logic [LUT_INPUTS-1:0]                                  data_in,
  input logic                                                   data_out,
  input logic [logic_cell_pkg::table_size(LUT_INPUTS):0]        cfg_q,
  input logic                                                   lut_y,
  input logic                                                   ff_q
);

  localparam int unsigned TOP = logic_cell_pkg::table_size(LUT_INPUTS);

  // R1: combinational mode shows the addressed table bit
  a_r1_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[TOP] == 1'b0) |-> (data_out == cfg_q[data_in]));

  // R2: flip-flop captures the table result while running
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (ff_q == $past(lut_y)));

  // R3: one chain step per shifting edge
  a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_so == $past(cfg_q[1])));

  // R5: flip-flop frozen while configuring
  a_r5_ff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(ff_q));

  // R6: serial output frozen while running
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_so));

  // R7: flip-flop is clear on the first edge after reset release
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ff_q == 1'b0));

endmodule

bind logic_cell logic_cell_chk #(.LUT_INPUTS(LUT_INPUTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_so   (cfg_so),
  .data_in  (data_in),
  .data_out (data_out),
  .cfg_q    (cfg_q),
  .lut_y    (lut_y),
  .ff_q     (ff_q)
);

// File: tb/logic_cell_bench.sv
`timescale 1ns/1ps
module logic_cell_bench;

  logic       clk;
  logic       rst_n;
  logic       cfg_en;
  logic       cfg_si;
  logic       so_a;
  logic       so_b;
  logic [1:0] data_in;
  logic       out_a;
  logic       out_b;

  int n_tests;
  int n_fail;
  bit done;

  logic_cell u_logic_cell (
    .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en), .cfg_si (cfg_si),
    .cfg_so (so_a), .data_in (data_in), .data_out (out_a)
  );

  logic_cell u_logic_cell_b (
    .clk (clk), .rst_n (rst_n), .cfg_en (cfg_en), .cfg_si (so_a),
    .cfg_so (so_b), .data_in (data_in), .data_out (out_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Shifts table bits 0..3 then the select bit; ends at a falling edge, cfg_en low.
  task automatic load_cfg(input logic [3:0] tbl, input logic sel);
    logic [4:0] word;
    word = {sel, tbl};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_si = word[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_si = 1'b0;
  endtask

  task automatic check_comb(input string req, input logic [3:0] tbl);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      data_in = k[1:0];
      #1;
      chk(req, out_a, tbl[k]);
    end
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_si = 1'b0; data_in = 2'd0;
    load_cfg(4'b1111, 1'b1);
    #1 chk("R7 reset state", out_a, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R7 held after release", out_a, 1'b0);
    @(negedge clk);
    chk("R7 config survived reset load", out_a, 1'b1);
  endtask

  task automatic t_comb;
    load_cfg(4'b1000, 1'b0);
    check_comb("R1 and", 4'b1000);
    load_cfg(4'b0110, 1'b0);
    check_comb("R1 xor", 4'b0110);
    load_cfg(4'b0100, 1'b0);
    check_comb("R1 index order", 4'b0100);
  endtask

  task automatic t_shift_out;
    logic [4:0] word;
    word = {1'b1, 4'b1011};
    load_cfg(4'b1011, 1'b1);
    for (int i = 0; i < 5; i++) begin
      #1 chk("R4 serial out order", so_a, word[i]);
      cfg_en = 1'b1;
      cfg_si = 1'b0;
      @(negedge clk);
    end
    cfg_en = 1'b0;
    #1 chk("R3 chain refilled with zeros", so_a, 1'b0);
  endtask

  task automatic t_reg;
    logic [3:0] tbl;
    logic       prev;
    tbl = 4'b0110;
    load_cfg(tbl, 1'b1);
    data_in = 2'd3;
    @(negedge clk);
    prev = tbl[3];
    chk("R2 registered start", out_a, prev);
    for (int k = 0; k < 4; k++) begin
      data_in = k[1:0];
      #1 chk("R2 no change before edge", out_a, prev);
      @(negedge clk);
      chk("R2 captured after edge", out_a, tbl[k]);
      prev = tbl[k];
    end
  endtask

  task automatic t_hold;
    data_in = 2'd0;
    load_cfg(4'b1111, 1'b1);
    @(negedge clk);
    chk("R5 preset one", out_a, 1'b1);
    load_cfg(4'b0000, 1'b1);
    #1 chk("R5 held through load", out_a, 1'b1);
    @(negedge clk);
    chk("R5 updates once running", out_a, 1'b0);
  endtask

  task automatic t_cfg_hold;
    load_cfg(4'b0110, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_si = ~cfg_si;
    end
    cfg_si = 1'b0;
    #1 chk("R6 serial out frozen", so_a, 1'b0);
    check_comb("R6 function unchanged", 4'b0110);
  endtask

  task automatic t_reset_mid;
    data_in = 2'd0;
    load_cfg(4'b1111, 1'b1);
    @(negedge clk);
    chk("R7 preset one", out_a, 1'b1);
    #2 rst_n = 1'b0;
    #1 chk("R7 async clear", out_a, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R7 chain kept", so_a, 1'b1);
    @(negedge clk);
    chk("R7 function kept", out_a, 1'b1);
  endtask

  task automatic t_cascade;
    load_cfg(4'b0001, 1'b0);
    load_cfg(4'b1110, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      data_in = k[1:0];
      #1;
      chk("R8 first cell or", out_a, (k != 0));
      chk("R8 second cell nor", out_b, (k == 0));
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    t_reset_state();
    t_comb();
    t_shift_out();
    t_reg();
    t_hold();
    t_cfg_hold();
    t_reset_mid();
    t_cascade();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule